// File: doc/BRIEF.md
# Reloading down-counter pulse timer

This block is a down-counting timer with a reload register. It produces a continuous square wave and a one-cycle interrupt pulse on every underflow. Software loads a start value (the preset) and a reload value through a simple register write port. Software then starts the timer through a control write, or hardware starts it with a rising edge on an asynchronous start pin. Once started, the counter steps down by one on every system-clock cycle in which the count-clock enable `tick` is high.

When the counter is at zero, the next tick is the underflow tick. In that tick the counter wraps to all ones, the square-wave output inverts and `irq` pulses. The tick after that loads the reload value minus one, so every period after the first spans reload + 1 ticks. The output also inverts once at start-up. Counting continues until software writes the control register with bit 0 cleared.

The behaviour is held in a four-state machine:
- **IDLE**: stopped.
- **LOAD**: started, waiting for the first tick to copy the preset into the counter.
- **COUNT**: decrementing.
- **WRAP**: the counter shows the underflow value.

The transitions are:
- IDLE→LOAD on a start request.
- LOAD→COUNT on a tick.
- COUNT→WRAP on a tick with the counter at zero.
- WRAP→COUNT on a tick.
- Any state→IDLE on a stop write.

Top module: `reload_pulse_timer`

## Requirements
- R1: After reset, `cnt_val`, the preset and reload registers, `running`, `pulse_out` and `irq` are all 0, and the state is IDLE.
- R2: In IDLE, a start request moves the timer to LOAD, and `running` is 1 from the next clock. A start request is either a write with `wr_sel`=2 and `wr_data[0]`=1, or a rising edge on `ext_start`. The edge passes a two-flop synchroniser and an edge detector, so it takes effect at the third rising clock edge after the pin rises. `cnt_val` keeps its previous value until the first tick, which copies the preset into it.
- R3: In COUNT, each clock with `tick`=1 and a nonzero counter lowers `cnt_val` by one. Without `tick`, `cnt_val` never changes.
- R4: In COUNT, a tick with `cnt_val`=0 makes `cnt_val` 0xFFFF at the next clock. `irq` is 1 for exactly that one clock cycle.
- R5: In WRAP, a tick loads the reload register value minus one (modulo 2^16) and returns to COUNT. With preset 4 and reload 5, ticking every cycle, the counter reads 4,3,2,1,0,0xFFFF,4,3,2,1,0,0xFFFF.
- R6: `pulse_out` inverts at the clock where the timer leaves IDLE and at each underflow. It changes at no other time.
- R7: A write with `wr_sel`=2 and `wr_data[0]`=0 returns any state to IDLE at the next clock. It takes priority over a tick or an `ext_start` edge in the same cycle. In IDLE, `cnt_val` and `pulse_out` hold. A start request while running is ignored and does not restart the count.
- R8: A write with `wr_sel`=0 sets the preset only in IDLE; while running it is ignored. A write with `wr_sel`=1 sets the reload register at any time and is first used at the next WRAP tick. `wr_sel`=3 does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 preset, 1 reload, 2 control |
| wr_data | input | 16 | Write data; control uses bit 0 as run/stop |
| tick | input | 1 | Count-clock enable, one system cycle per count |
| ext_start | input | 1 | Asynchronous start pin, rising edge starts |
| cnt_val | output | 16 | Current counter value |
| running | output | 1 | High while the timer is not in IDLE |
| pulse_out | output | 1 | Square-wave output flip-flop |
| irq | output | 1 | One-cycle underflow interrupt pulse |

## Verification
The hardest case to reach is a run of several back-to-back periods in which the reload register is rewritten mid-period. The new value must then appear only after the following underflow. Short preset and reload values (0 to 7) keep underflows frequent, so random reload writes often land inside a running period. Random stop writes and `ext_start` toggles also collide with ticks and with the WRAP state. A directed run replays the preset 4 / reload 5 sequence tick by tick.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_COUNT = 2'd2,
        ST_WRAP  = 2'd3
    } rpt_state_e;

    localparam logic [1:0] SEL_PRESET = 2'd0;
    localparam logic [1:0] SEL_RELOAD = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
endpackage

// File: rtl/rpt_start_sync.sv
module rpt_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain_q;

    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= 1'b0;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    // last synchroniser stage against the extra delay flop
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/rpt_cfg_regs.sv
module rpt_cfg_regs
    import rpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         idle,
    output logic [W-1:0] preset_q,
    output logic [W-1:0] reload_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_q <= '0;
            reload_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_PRESET && idle) preset_q <= wr_data;
            if (wr_sel == SEL_RELOAD)         reload_q <= wr_data;
        end
    end
endmodule

// File: rtl/rpt_fsm.sv
module rpt_fsm
    import rpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_start,
    input  logic         sw_stop,
    input  logic         hw_start,
    input  logic         tick,
    input  logic [W-1:0] preset_q,
    input  logic [W-1:0] reload_q,
    output rpt_state_e   state_q,
    output logic [W-1:0] cnt_q,
    output logic         pulse_q,
    output logic         irq_q
);
    localparam logic [W-1:0] WRAP_VAL = '1;
    localparam logic [W-1:0] ONE      = W'(1);

    rpt_state_e state_d;
    logic       start_req;

    assign start_req = sw_start | hw_start;

    always_comb begin
        state_d = state_q;
        if (sw_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start_req)                 state_d = ST_LOAD;
                ST_LOAD:  if (tick)                      state_d = ST_COUNT;
                ST_COUNT: if (tick && cnt_q == '0)       state_d = ST_WRAP;
                ST_WRAP:  if (tick)                      state_d = ST_COUNT;
                default:                                 state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (!sw_stop) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (start_req) pulse_q <= ~pulse_q;
                    end
                    ST_LOAD: begin
                        if (tick) cnt_q <= preset_q;
                    end
                    ST_COUNT: begin
                        if (tick) begin
                            if (cnt_q == '0) begin
                                cnt_q   <= WRAP_VAL;
                                pulse_q <= ~pulse_q;
                                irq_q   <= 1'b1;
                            end else begin
                                cnt_q <= cnt_q - ONE;
                            end
                        end
                    end
                    ST_WRAP: begin
                        if (tick) cnt_q <= reload_q - ONE;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/reload_pulse_timer.sv
module reload_pulse_timer
    import rpt_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         tick,
    input  logic         ext_start,
    output logic [W-1:0] cnt_val,
    output logic         running,
    output logic         pulse_out,
    output logic         irq
);
    rpt_state_e   state_q;
    logic [W-1:0] preset_q;
    logic [W-1:0] reload_q;
    logic         hw_start;
    logic         ctrl_wr;
    logic         sw_start;
    logic         sw_stop;

    assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
    assign sw_start = ctrl_wr &&  wr_data[0];
    assign sw_stop  = ctrl_wr && !wr_data[0];

    rpt_start_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_start),
        .rise     (hw_start)
    );

    rpt_cfg_regs #(.W(W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .idle     (state_q == ST_IDLE),
        .preset_q (preset_q),
        .reload_q (reload_q)
    );

    rpt_fsm #(.W(W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_start (sw_start),
        .sw_stop  (sw_stop),
        .hw_start (hw_start),
        .tick     (tick),
        .preset_q (preset_q),
        .reload_q (reload_q),
        .state_q  (state_q),
        .cnt_q    (cnt_val),
        .pulse_q  (pulse_out),
        .irq_q    (irq)
    );

    assign running = (state_q != ST_IDLE);
endmodule

// File: rtl/rpt_checker.sv
module rpt_checker
    import rpt_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic [W-1:0] wr_data,
    input logic         tick,
    input logic [W-1:0] cnt_val,
    input logic         running,
    input logic         pulse_out,
    input logic         irq,
    input rpt_state_e   state_q,
    input logic [W-1:0] preset_q,
    input logic [W-1:0] reload_q
);
    logic stop_wr;
    assign stop_wr = wr_en && wr_sel == SEL_CTRL && !wr_data[0];

    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_val));

    assert_underflow_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && tick && cnt_val == '0 && !stop_wr) |=> (cnt_val == '1 && irq));

    assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_reload_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRAP && tick && !stop_wr) |=> cnt_val == $past(reload_q) - W'(1));

    assert_irq_toggles_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pulse_out != $past(pulse_out));

    assert_start_toggles_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> pulse_out != $past(pulse_out));

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> ($stable(pulse_out) && $stable(cnt_val)));

    assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> !running);

    assert_preset_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_en && wr_sel == SEL_PRESET) |=> $stable(preset_q));
endmodule

bind reload_pulse_timer rpt_checker #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .tick      (tick),
    .cnt_val   (cnt_val),
    .running   (running),
    .pulse_out (pulse_out),
    .irq       (irq),
    .state_q   (state_q),
    .preset_q  (preset_q),
    .reload_q  (reload_q)
);

// File: tb/reload_pulse_timer_tb.sv
`timescale 1ns/1ps
module reload_pulse_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        tick = 1'b0;
    logic        ext_start = 1'b0;
    logic [15:0] cnt_val;
    logic        running;
    logic        pulse_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    reload_pulse_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tick(tick), .ext_start(ext_start),
        .cnt_val(cnt_val), .running(running), .pulse_out(pulse_out), .irq(irq)
    );

    // ---------------- reference model built from the requirements ----------
    localparam int M_IDLE = 0, M_LOAD = 1, M_COUNT = 2, M_WRAP = 3;
    int          m_st = M_IDLE;
    logic [15:0] m_cnt = 0, m_pre = 0, m_rel = 0;
    logic        m_pulse = 0, m_irq = 0;
    logic [2:0]  m_sh = 0;

    function automatic logic [15:0] next_count(int st, logic [15:0] c,
                                               logic [15:0] pre, logic [15:0] rel);
        if (st == M_LOAD)  return pre;
        if (st == M_WRAP)  return rel - 16'd1;
        if (c == 16'd0)    return 16'hFFFF;
        return c - 16'd1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = M_IDLE; m_cnt = 0; m_pre = 0; m_rel = 0;
            m_pulse = 0; m_irq = 0; m_sh = 0;
        end else begin
            logic edge_seen, sw_go, sw_halt;
            int old_st;
            logic [15:0] old_rel;
            edge_seen = m_sh[1] & ~m_sh[2];
            m_sh = {m_sh[1:0], ext_start};
            sw_go   = wr_en && wr_sel == 2'd2 &&  wr_data[0];
            sw_halt = wr_en && wr_sel == 2'd2 && !wr_data[0];
            old_st = m_st;
            old_rel = m_rel;
            m_irq = 0;
            if (sw_halt) m_st = M_IDLE;
            else if (m_st == M_IDLE) begin
                if (sw_go || edge_seen) begin m_st = M_LOAD; m_pulse = ~m_pulse; end
            end else if (tick) begin
                if (m_st == M_COUNT && m_cnt == 0) begin
                    m_irq = 1; m_pulse = ~m_pulse; m_st = M_WRAP;
                end else if (m_st != M_COUNT) m_st = M_COUNT;
                m_cnt = next_count(old_st, m_cnt, m_pre, old_rel);
            end
            if (wr_en && wr_sel == 2'd0 && old_st == M_IDLE) m_pre = wr_data;
            if (wr_en && wr_sel == 2'd1) m_rel = wr_data;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison, sampled at the falling edge
    bit cmp_on = 1'b0;
    always @(negedge clk) if (cmp_on && rst_n) begin
        chk("R3 cnt_val",   {16'd0, cnt_val}, {16'd0, m_cnt});
        chk("R4 irq",       {31'd0, irq},       {31'd0, m_irq});
        chk("R6 pulse_out", {31'd0, pulse_out}, {31'd0, m_pulse});
        chk("R2 running",   {31'd0, running},   {31'd0, m_st != M_IDLE});
    end

    task automatic wr(logic [1:0] s, logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] prev;
        logic [15:0] exp_seq [12];
        bit saw;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 cnt",   {16'd0, cnt_val}, 0);
        chk("R1 run",   {31'd0, running}, 0);
        chk("R1 pulse", {31'd0, pulse_out}, 0);
        chk("R1 irq",   {31'd0, irq}, 0);
        rst_n = 1;
        cmp_on = 1;

        // R5 directed example: preset 4, reload 5, tick every cycle
        wr(2'd0, 16'd4);
        wr(2'd1, 16'd5);
        prev = cnt_val;
        @(negedge clk); wr_en = 1; wr_sel = 2'd2; wr_data = 16'd1;
        @(negedge clk); wr_en = 0;
        chk("R2 prev value kept", {16'd0, cnt_val}, {16'd0, prev});
        tick = 1;
        exp_seq = '{16'd4,16'd3,16'd2,16'd1,16'd0,16'hFFFF,16'd4,16'd3,16'd2,16'd1,16'd0,16'hFFFF};
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk("R5 sequence", {16'd0, cnt_val}, {16'd0, exp_seq[i]});
            if (i == 5 || i == 11) chk("R4 irq at wrap", {31'd0, irq}, 1);
        end
        tick = 0;

        // R8 preset write while running ignored; R7 restart write ignored
        wr(2'd0, 16'd2);
        wr(2'd2, 16'd1);
        chk("R7 no restart", {31'd0, running}, 1);
        // R7 stop, then the counter holds
        wr(2'd2, 16'd0);
        chk("R7 stopped", {31'd0, running}, 0);
        prev = cnt_val;
        tick = 1; repeat (4) @(negedge clk); tick = 0;
        chk("R7 hold in idle", {16'd0, cnt_val}, {16'd0, prev});
        // R8 restart shows the preset was not changed by the ignored write
        wr(2'd2, 16'd1);
        tick = 1; @(negedge clk); tick = 0;
        chk("R8 preset kept", {16'd0, cnt_val}, 16'd4);
        wr(2'd2, 16'd0);

        // R2 external start: third clock after the pin rises
        @(negedge clk); ext_start = 1;
        saw = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (i < 2) chk("R2 ext not yet", {31'd0, running}, 0);
            else saw = running;
        end
        chk("R2 ext start", {31'd0, saw}, 1);
        ext_start = 0;

        // R5 reload 0 wraps to 0xFFFF at the reload tick (checked by the model)
        wr(2'd2, 16'd0);
        wr(2'd0, 16'd0);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd1);
        tick = 1; repeat (3) @(negedge clk); tick = 0;
        chk("R5 reload zero", {16'd0, cnt_val}, 16'hFFFF);

        // constrained random phase
        for (int n = 0; n < 6000; n++) begin
            int r;
            @(negedge clk);
            r = $urandom_range(0, 99);
            tick = ($urandom_range(0, 2) != 0);
            wr_en = 0;
            if (r < 6) begin
                wr_en = 1; wr_sel = 2'd1; wr_data = 16'($urandom_range(0, 7));
            end else if (r < 9) begin
                wr_en = 1; wr_sel = 2'd0; wr_data = 16'($urandom_range(0, 7));
            end else if (r < 11) begin
                wr_en = 1; wr_sel = 2'd2; wr_data = 16'($urandom_range(0, 1));
            end else if (r < 12) begin
                wr_en = 1; wr_sel = 2'd3; wr_data = 16'($urandom);
            end
            if ($urandom_range(0, 29) == 0) ext_start = ~ext_start;
        end
        @(negedge clk);
        wr_en = 0; tick = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule